// File: doc/BRIEF.md
# Programmable CRC Accumulator

This block is a memory-mapped 32-bit CRC engine on a simple register bus with per-byte write strobes. Software programs a generator polynomial and a starting value. It then issues a reset command that copies the starting value into the accumulator. After that it writes message data to the data register, either as whole 32-bit words or as single bytes. Reads of the same address return the running CRC at any time. Each write is folded in during the cycle it is accepted, shifting the most significant bit first.

The control register selects how input bits are reordered before folding: none, reversed within each byte, or reversed across the whole word. It also selects whether the value read back is bit-reversed. With the polynomial in normal form, an all-ones start, whole-word input reversal and output reversal, the engine produces the reflected CRC-32 and CRC-32C register contents used by common byte-stream software. The final inversion is left to software. A partial result can be read, saved, and later reloaded as the starting value, so a computation can resume.

Top module: `crc_acc`

## Requirements
- R1: After reset the data address reads 0xFFFFFFFF, control reads 0, the starting value reads 0xFFFFFFFF and the polynomial reads 0x04C11DB7.
- R2: Data sits at byte address 0x00, control at 0x08, starting value at 0x10 and polynomial at 0x14, and any other address reads 0. The starting value and the polynomial are written per byte lane, so only lanes whose strobe is set change, and both read back as stored.
- R3: A control write with lane 0 strobed stores bits [7:5]. If bit 0 of the written data is 1, the accumulator is loaded from the starting value. Control reads back bits [7:5] as stored, and every other bit, bit 0 included, reads 0.
- R4: A data write with all four strobes set folds the 32-bit word, after input reordering, into the accumulator bit by bit from bit 31 down to bit 0. For each bit the feedback is the accumulator MSB XOR the data bit; the accumulator shifts left one place and is XORed with the polynomial when the feedback is 1. The new value is readable in the next cycle.
- R5: A data write with exactly one strobe set folds only the byte on that lane, from its bit 7 down to bit 0. When control bit 5 is 1, the byte is bit-reversed first.
- R6: For word writes, control bits [6:5] select the input order: 2'b01 reverses the bits inside each byte in place, 2'b11 reverses all 32 bits, and 2'b00 or 2'b10 leaves the word unchanged.
- R7: When control bit 7 is 1, a read of the data address returns the accumulator with bit i moved to bit 31-i.
- R8: A data write whose strobes are none, two or three lanes leaves the accumulator unchanged.
- R9: A value read from the data address (bit 7 clear), written back as the starting value and reloaded, continues the computation exactly as if it had not been interrupted.
- R10: With polynomial 0x04C11DB7 (or 0x1EDC6F41), start 0xFFFFFFFF, control 0x61 and then 0xE0, a mix of byte and word writes of "123456789" reads back a value whose inverse is 0xCBF43926 (or 0xE3069283).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 5 | Byte address of the access |
| busWrEn | input | 1 | Write request for this cycle |
| busByteEn | input | 4 | Byte-lane write strobes |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |

## Verification
Assertions check, on every cycle, that at most one accumulator action is requested at a time and that the accumulator holds its value in any cycle with no such action. They also check that a reset command leaves the starting value in the accumulator, and that the stored registers move only on a bus write to their own address. The folding arithmetic itself can only be shown by the bench's scenarios: exhaustive byte sweeps in every reordering mode, chained word sweeps under both polynomials, every strobe pattern that must be ignored, the save-and-resume sequence and the two standard check strings.

// File: rtl/crc_acc_pkg.sv
package crc_acc_pkg;

  typedef enum logic [1:0] {
    REV_NONE = 2'b00,
    REV_BYTE = 2'b01,
    REV_ALT  = 2'b10,
    REV_WORD = 2'b11
  } inRev_e;

  typedef struct packed {
    logic       loadInit;
    logic       foldWord;
    logic       foldByte;
    logic [7:0] byteData;
  } crcStrobe_t;

endpackage

// File: rtl/crc_acc_ctrl.sv
module crc_acc_ctrl
  import crc_acc_pkg::*;
#(
  parameter int CRC_W     = 32,
  parameter int ADDR_W    = 5,
  parameter int OFF_DATA  = 'h00,
  parameter int OFF_CTRL  = 'h08,
  parameter int OFF_INIT  = 'h10,
  parameter int OFF_POLY  = 'h14,
  parameter logic [CRC_W-1:0] INIT_RST = 32'hFFFF_FFFF,
  parameter logic [CRC_W-1:0] POLY_RST = 32'h04C1_1DB7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [CRC_W/8-1:0] busByteEn,
  input  logic [CRC_W-1:0]  busWrData,
  input  logic [CRC_W-1:0]  accView,
  output crcStrobe_t        strb,
  output inRev_e            inMode,
  output logic              outRev,
  output logic [CRC_W-1:0]  initVal,
  output logic [CRC_W-1:0]  polyVal,
  output logic [CRC_W-1:0]  busRdData
);
  localparam int BYTES = CRC_W / 8;
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_INIT = ADDR_W'(OFF_INIT);
  localparam logic [ADDR_W-1:0] A_POLY = ADDR_W'(OFF_POLY);

  logic hitData, hitCtrl, hitInit, hitPoly;
  logic oneLane, allLanes;
  logic [7:0] laneByte;
  logic [2:0] ctrlBits;
  logic [CRC_W-1:0] initReg, polyReg;

  assign hitData  = busWrEn && (busAddr == A_DATA);
  assign hitCtrl  = busWrEn && (busAddr == A_CTRL);
  assign hitInit  = busWrEn && (busAddr == A_INIT);
  assign hitPoly  = busWrEn && (busAddr == A_POLY);
  assign oneLane  = ($countones(busByteEn) == 1);
  assign allLanes = &busByteEn;

  always_comb begin
    laneByte = 8'h00;
    for (int i = 0; i < BYTES; i++) begin
      if (busByteEn[i]) laneByte = busWrData[8*i +: 8];
    end
  end

  always_comb begin
    strb.loadInit = hitCtrl && busByteEn[0] && busWrData[0];
    strb.foldWord = hitData && allLanes;
    strb.foldByte = hitData && oneLane;
    strb.byteData = laneByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlBits <= 3'b000;
      initReg  <= INIT_RST;
      polyReg  <= POLY_RST;
    end else begin
      if (hitCtrl && busByteEn[0]) ctrlBits <= busWrData[7:5];
      for (int i = 0; i < BYTES; i++) begin
        if (hitInit && busByteEn[i]) initReg[8*i +: 8] <= busWrData[8*i +: 8];
        if (hitPoly && busByteEn[i]) polyReg[8*i +: 8] <= busWrData[8*i +: 8];
      end
    end
  end

  assign inMode  = inRev_e'(ctrlBits[1:0]);
  assign outRev  = ctrlBits[2];
  assign initVal = initReg;
  assign polyVal = polyReg;

  always_comb begin
    busRdData = '0;
    if (busAddr == A_DATA)      busRdData = accView;
    else if (busAddr == A_CTRL) busRdData[7:5] = ctrlBits;
    else if (busAddr == A_INIT) busRdData = initReg;
    else if (busAddr == A_POLY) busRdData = polyReg;
  end

  // R4 R5 R3: a single accumulator action per cycle
  assert_one_action_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadInit, strb.foldWord, strb.foldByte}));

  // R3: mode bits move only on a lane-0 control write
  assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busAddr == A_CTRL && busByteEn[0]) |=> ($stable(inMode) && $stable(outRev)));

  // R2: stored values move only on a bus write
  assert_regs_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> ($stable(initVal) && $stable(polyVal)));

endmodule

// File: rtl/crc_acc_datapath.sv
module crc_acc_datapath
  import crc_acc_pkg::*;
#(
  parameter int CRC_W = 32,
  parameter logic [CRC_W-1:0] ACC_RST = 32'hFFFF_FFFF
) (
  input  logic             clk,
  input  logic             rstN,
  input  crcStrobe_t       strb,
  input  inRev_e           inMode,
  input  logic             outRev,
  input  logic [CRC_W-1:0] wordIn,
  input  logic [CRC_W-1:0] initVal,
  input  logic [CRC_W-1:0] polyVal,
  output logic [CRC_W-1:0] accView
);
  localparam int BYTES = CRC_W / 8;

  logic [CRC_W-1:0] acc, wordShaped, wordNext, byteNext;
  logic [7:0] byteShaped;
  logic wFb, bFb;

  always_comb begin
    wordShaped = wordIn;
    case (inMode)
      REV_BYTE: begin
        for (int b = 0; b < BYTES; b++)
          for (int k = 0; k < 8; k++)
            wordShaped[8*b + k] = wordIn[8*b + 7 - k];
      end
      REV_WORD: begin
        for (int k = 0; k < CRC_W; k++) wordShaped[k] = wordIn[CRC_W-1-k];
      end
      default: wordShaped = wordIn;
    endcase
  end

  always_comb begin
    for (int k = 0; k < 8; k++)
      byteShaped[k] = inMode[0] ? strb.byteData[7-k] : strb.byteData[k];
  end

  always_comb begin
    wFb = 1'b0;
    wordNext = acc;
    for (int i = 0; i < CRC_W; i++) begin
      wFb = wordNext[CRC_W-1] ^ wordShaped[CRC_W-1-i];
      wordNext = {wordNext[CRC_W-2:0], 1'b0};
      if (wFb) wordNext = wordNext ^ polyVal;
    end
  end

  always_comb begin
    bFb = 1'b0;
    byteNext = acc;
    for (int i = 0; i < 8; i++) begin
      bFb = byteNext[CRC_W-1] ^ byteShaped[7-i];
      byteNext = {byteNext[CRC_W-2:0], 1'b0};
      if (bFb) byteNext = byteNext ^ polyVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              acc <= ACC_RST;
    else if (strb.loadInit) acc <= initVal;
    else if (strb.foldWord) acc <= wordNext;
    else if (strb.foldByte) acc <= byteNext;
  end

  always_comb begin
    for (int k = 0; k < CRC_W; k++) accView[k] = outRev ? acc[CRC_W-1-k] : acc[k];
  end

  // R3: reset command copies the starting value
  assert_load_init_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadInit |=> (acc == $past(initVal)));

  // R8: no action, no change
  assert_acc_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.loadInit || strb.foldWord || strb.foldByte) |=> $stable(acc));

endmodule

// File: rtl/crc_acc.sv
module crc_acc
  import crc_acc_pkg::*;
#(
  parameter int CRC_W  = 32,
  parameter int ADDR_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [CRC_W/8-1:0] busByteEn,
  input  logic [CRC_W-1:0]   busWrData,
  output logic [CRC_W-1:0]   busRdData
);
  crcStrobe_t strb;
  inRev_e inMode;
  logic outRev;
  logic [CRC_W-1:0] initVal, polyVal, accView;

  crc_acc_ctrl #(.CRC_W(CRC_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busByteEn(busByteEn), .busWrData(busWrData), .accView(accView),
    .strb(strb), .inMode(inMode), .outRev(outRev), .initVal(initVal),
    .polyVal(polyVal), .busRdData(busRdData)
  );

  crc_acc_datapath #(.CRC_W(CRC_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .inMode(inMode), .outRev(outRev),
    .wordIn(busWrData), .initVal(initVal), .polyVal(polyVal), .accView(accView)
  );

endmodule

// File: tb/crc_acc_bench.sv
module crc_acc_bench;
  localparam logic [4:0] A_DATA = 5'h00, A_CTRL = 5'h08, A_INIT = 5'h10, A_POLY = 5'h14;

  logic clk = 1'b0;
  logic rstN;
  logic [4:0] busAddr;
  logic busWrEn;
  logic [3:0] busByteEn;
  logic [31:0] busWrData, busRdData;
  int nChecks = 0, nFail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  crc_acc u_crc_acc (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busByteEn(busByteEn), .busWrData(busWrData), .busRdData(busRdData)
  );

  function automatic logic [31:0] rev32(input logic [31:0] v);
    for (int k = 0; k < 32; k++) rev32[k] = v[31-k];
  endfunction
  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int k = 0; k < 8; k++) rev8[k] = v[7-k];
  endfunction
  function automatic logic [31:0] shapeWord(input logic [31:0] d, input logic [1:0] mode);
    shapeWord = d;
    if (mode == 2'b01) for (int b = 0; b < 4; b++) shapeWord[8*b +: 8] = rev8(d[8*b +: 8]);
    if (mode == 2'b11) shapeWord = rev32(d);
  endfunction
  function automatic logic [31:0] foldBitsM(input logic [31:0] c, input logic [31:0] d,
                                            input int n, input logic [31:0] p);
    logic fb;
    for (int i = 0; i < n; i++) begin
      fb = c[31] ^ d[31-i];
      c = c << 1;
      if (fb) c = c ^ p;
    end
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    busAddr = a; busWrData = d; busByteEn = be; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busByteEn = 4'h0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] r, expAcc, poly, lfsr, save, cont;
    rstN = 1'b0; busWrEn = 1'b0; busAddr = 5'h0; busByteEn = 4'h0; busWrData = 32'h0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(A_DATA, r); check("R1 data", r, 32'hFFFF_FFFF);
    rd(A_CTRL, r); check("R1 ctrl", r, 32'h0);
    rd(A_INIT, r); check("R1 init", r, 32'hFFFF_FFFF);
    rd(A_POLY, r); check("R1 poly", r, 32'h04C1_1DB7);

    // R2 unmapped addresses
    rd(5'h04, r); check("R2 unmapped 04", r, 32'h0);
    rd(5'h0C, r); check("R2 unmapped 0C", r, 32'h0);
    rd(5'h18, r); check("R2 unmapped 18", r, 32'h0);

    // R2 byte-lane writes on init and poly
    wr(A_INIT, 32'h1234_5678, 4'hF);
    wr(A_INIT, 32'hAABB_CCDD, 4'b0101);
    rd(A_INIT, r); check("R2 init lanes", r, 32'h12BB_56DD);
    wr(A_POLY, 32'hCAFE_F00D, 4'b1010);
    rd(A_POLY, r); check("R2 poly lanes", r, 32'hCAC1_F0B7);

    // R3 reset command and control readback
    wr(A_CTRL, 32'hFFFF_FFFF, 4'hF);
    rd(A_CTRL, r); check("R3 ctrl readback", r, 32'h0000_00E0);
    rd(A_DATA, r); check("R3 load init", r, rev32(32'h12BB_56DD));
    wr(A_CTRL, 32'h0000_00E0, 4'b1110);
    rd(A_CTRL, r); check("R3 ctrl no lane0", r, 32'h0000_00E0);
    wr(A_INIT, 32'hFFFF_FFFF, 4'hF);
    wr(A_POLY, 32'h04C1_1DB7, 4'hF);

    // R5 byte sweep in every mode
    for (int m = 0; m < 4; m++) begin
      wr(A_CTRL, {24'h0, 1'b0, 2'(m), 5'h01}, 4'h1);
      expAcc = 32'hFFFF_FFFF;
      for (int v = 0; v < 256; v++) begin
        logic [7:0] b;
        b = (m[0]) ? rev8(8'(v)) : 8'(v);
        wr(A_DATA, 32'(v) << (8 * (v % 4)), 4'(1 << (v % 4)));
        expAcc = foldBitsM(expAcc, {b, 24'h0}, 8, 32'h04C1_1DB7);
        rd(A_DATA, r); check("R5 byte fold", r, expAcc);
      end
    end

    // R4 R6 word sweeps with both polynomials
    lfsr = 32'h1;
    for (int m = 0; m < 4; m++) begin
      poly = (m % 2 == 0) ? 32'h04C1_1DB7 : 32'h1EDC_6F41;
      wr(A_POLY, poly, 4'hF);
      wr(A_CTRL, {24'h0, 1'b0, 2'(m), 5'h01}, 4'h1);
      expAcc = 32'hFFFF_FFFF;
      for (int k = 0; k < 64; k++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]} ^ 32'h9E37_79B9;
        wr(A_DATA, lfsr, 4'hF);
        expAcc = foldBitsM(expAcc, shapeWord(lfsr, 2'(m)), 32, poly);
        rd(A_DATA, r); check("R4 R6 word fold", r, expAcc);
      end
    end

    // R8 ignored strobe patterns
    for (int be = 0; be < 15; be++) begin
      if ($countones(4'(be)) != 1) begin
        wr(A_DATA, 32'hDEAD_BEEF, 4'(be));
        rd(A_DATA, r); check("R8 ignored strobes", r, expAcc);
      end
    end

    // R7 output reversal without reload
    wr(A_CTRL, 32'h0000_00E0, 4'h1);
    rd(A_DATA, r); check("R7 output reversed", r, rev32(expAcc));
    wr(A_CTRL, 32'h0000_0060, 4'h1);
    rd(A_DATA, r); check("R7 output plain", r, expAcc);

    // R9 save and resume
    rd(A_DATA, save);
    wr(A_DATA, 32'h0BAD_F00D, 4'hF);
    rd(A_DATA, cont);
    check("R9 continuous", cont, foldBitsM(save, rev32(32'h0BAD_F00D), 32, poly));
    wr(A_INIT, save, 4'hF);
    wr(A_CTRL, 32'h0000_0061, 4'h1);
    wr(A_DATA, 32'h0BAD_F00D, 4'hF);
    rd(A_DATA, r); check("R9 resumed", r, cont);

    // R10 standard check strings
    wr(A_INIT, 32'hFFFF_FFFF, 4'hF);
    wr(A_POLY, 32'h04C1_1DB7, 4'hF);
    wr(A_CTRL, 32'h0000_0061, 4'h1);
    wr(A_CTRL, 32'h0000_00E0, 4'h1);
    wr(A_DATA, 32'h0000_0031, 4'b0001);
    wr(A_DATA, 32'h3534_3332, 4'hF);
    wr(A_DATA, 32'h3938_3736, 4'hF);
    rd(A_DATA, r); check("R10 crc32", ~r, 32'hCBF4_3926);
    wr(A_POLY, 32'h1EDC_6F41, 4'hF);
    wr(A_CTRL, 32'h0000_0061, 4'h1);
    wr(A_CTRL, 32'h0000_00E0, 4'h1);
    wr(A_DATA, 32'h3433_3231, 4'hF);
    wr(A_DATA, 32'h3837_3635, 4'hF);
    wr(A_DATA, 32'h0039_0000, 4'b0100);
    rd(A_DATA, r); check("R10 crc32c", ~r, 32'hE306_9283);

    finished = 1;
    summary();
    $finish;
  end
endmodule